// File: doc/BRIEF.md
# Retriggerable Delayed Pulse Generator

This block turns each start trigger on a gate input into one output pulse, or into a short fixed group of pulses. The delay before the first pulse, the pulse high time and the low gap between the pulses of a group are all counted in active edges of a separate source input. The source input and the gate input are asynchronous. Both are synchronized and edge-detected on the system clock. A configuration input selects whether the source counts on its rising or falling edges.

A generation runs from the accepted trigger until the end of its last pulse, and the busy output is high for that whole time. Gate edges that arrive during a generation have no effect. After the generation ends, the block waits for the next trigger. A mode input selects whether every trigger waits the full programmed delay, or only the first trigger after arming does. When the delay is skipped, the block still waits a two-edge minimum. The configuration is captured when a trigger is accepted, so changes made during a generation do not affect it.

Top module: `retrig_pulse_gen`

## Requirements
- R1: During and after a synchronous reset (rst_n low), pulse_out and busy are 0 until a trigger is accepted.
- R2: A rising gate_in edge seen while enable is 1 and busy is 0 is accepted. pulse_out then rises on the Dth active source edge after acceptance, where D is delay_ticks, raised to 2 when it is below 2.
- R3: Each pulse stays high for max(width_ticks,1) active source edges.
- R4: A generation contains max(pulse_count,1) pulses. Between two consecutive pulses, the output is low for max(gap_ticks,1) active source edges.
- R5: When delay_every is 1, every trigger uses the programmed delay from R2. When delay_every is 0, only the first trigger accepted after enable rises (or after reset) uses it, and later triggers wait 2 active edges.
- R6: Gate edges arriving while busy is 1 start nothing. The running generation continues unchanged, and no extra pulse follows it.
- R7: busy is 1 from the cycle after acceptance until the last pulse ends. busy falls on the same clock as the falling edge of the final pulse, and pulse_out is never 1 while busy is 0.
- R8: When src_fall_sel is 0, the rising edges of src_in are active. When it is 1, the falling edges are active. pulse_out only changes after an active edge, or because of enable.
- R9: The delay, width, gap, count and delay-mode inputs are captured at acceptance. Changing them during a generation does not alter that generation.
- R10: While enable is 0, the block is idle (busy=0, pulse_out=0) one clock later and ignores gate_in. A generation that is running when enable falls is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Arms the generator; low forces idle |
| gate_in | input | 1 | Asynchronous start trigger, rising edge active |
| src_in | input | 1 | Asynchronous timebase whose edges are counted |
| src_fall_sel | input | 1 | 0: count rising source edges, 1: falling |
| delay_every | input | 1 | 1: full delay on every trigger, 0: first trigger only |
| delay_ticks | input | CNT_W | Delay from trigger to first pulse, in active edges |
| width_ticks | input | CNT_W | High time of each pulse, in active edges |
| gap_ticks | input | CNT_W | Low time between pulses of a group, in active edges |
| pulse_count | input | NUM_W | Pulses per trigger |
| pulse_out | output | 1 | Generated pulse output |
| busy | output | 1 | High while a generation is in progress |

## Verification
The assertions check several rules on every cycle. The output never changes without an active source edge unless enable intervenes, and it never rises within one clock of acceptance. It is never high while busy is low. busy only falls together with the end of a pulse or because of a disable, and a disable idles the block on the next clock. The exact edge counts for the delay, width, gap and pulse number can only be shown by the bench scenarios. The same holds for the choice between full and minimum delay across retriggers, the rejection of gate edges during a generation, and the capture of the configuration at acceptance. The bench measures all of these by counting the source edges it drives itself.

// File: rtl/rdpg_pkg.sv
`timescale 1ns/1ps
// Package: shared phase type and timing constants for the retriggerable
// delayed pulse generator. Assumes nothing beyond IEEE 1800-2017.
package rdpg_pkg;

    // Sequencer phase: waiting, pre-pulse delay, pulse high, inter-pulse low.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phase_e;

    // Smallest number of active source edges between trigger and first pulse.
    localparam int unsigned MIN_LEAD = 2;

endpackage

// File: rtl/rdpg_sync_edge.sv
`timescale 1ns/1ps
// Module: rdpg_sync_edge
// Brings an asynchronous level into the clk domain through a STAGES-deep
// flop chain and emits a one-cycle pulse on the selected edge.
// Assumes the input stays at each level for at least two clk periods.
module rdpg_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic fall_sel,
    output logic edge_pulse
);

    logic [STAGES-1:0] chain;
    logic              last_lvl;
    logic              cur_lvl;

    assign cur_lvl = chain[STAGES-1];

    // Synchronizer chain and previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain    <= '0;
            last_lvl <= 1'b0;
        end else begin
            chain    <= {chain[STAGES-2:0], async_in};
            last_lvl <= cur_lvl;
        end
    end

    // Edge select: rising when fall_sel is 0, falling when it is 1.
    always_comb begin
        if (fall_sel) edge_pulse = last_lvl & ~cur_lvl;
        else          edge_pulse = ~last_lvl & cur_lvl;
    end

endmodule

// File: rtl/rdpg_cfg_latch.sv
`timescale 1ns/1ps
// Module: rdpg_cfg_latch
// Captures the timing configuration when a trigger is accepted and applies
// the floors: lead >= MIN_LEAD, width/gap/count >= 1. A skipped delay is
// replaced by MIN_LEAD. Assumes load is a single-cycle strobe.
module rdpg_cfg_latch
    import rdpg_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             full_delay,
    input  logic [CNT_W-1:0] delay_raw,
    input  logic [CNT_W-1:0] width_raw,
    input  logic [CNT_W-1:0] gap_raw,
    input  logic [NUM_W-1:0] count_raw,
    output logic [CNT_W-1:0] lead_q,
    output logic [CNT_W-1:0] width_q,
    output logic [CNT_W-1:0] gap_q,
    output logic [NUM_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] LEAD_FLOOR = CNT_W'(MIN_LEAD);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
    localparam logic [NUM_W-1:0] NUM_ONE    = NUM_W'(1);

    logic [CNT_W-1:0] lead_n;
    logic [CNT_W-1:0] width_n;
    logic [CNT_W-1:0] gap_n;
    logic [NUM_W-1:0] count_n;

    // Floors and delay-mode selection applied to the raw inputs.
    always_comb begin
        if (full_delay && (delay_raw > LEAD_FLOOR)) lead_n = delay_raw;
        else                                        lead_n = LEAD_FLOOR;
        width_n = (width_raw == '0) ? CNT_ONE : width_raw;
        gap_n   = (gap_raw   == '0) ? CNT_ONE : gap_raw;
        count_n = (count_raw == '0) ? NUM_ONE : count_raw;
    end

    // Holding registers, written only on trigger acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q  <= LEAD_FLOOR;
            width_q <= CNT_ONE;
            gap_q   <= CNT_ONE;
            count_q <= NUM_ONE;
        end else if (load) begin
            lead_q  <= lead_n;
            width_q <= width_n;
            gap_q   <= gap_n;
            count_q <= count_n;
        end
    end

endmodule

// File: rtl/rdpg_seq.sv
`timescale 1ns/1ps
// Module: rdpg_seq
// Phase sequencer: accepts a trigger only when idle and enabled, then
// counts active source ticks through delay, high and low phases until the
// programmed number of pulses is done. Assumes the cfg_* inputs are stable
// from the cycle after accept until the generation ends.
module rdpg_seq
    import rdpg_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic             tick,
    input  logic             delay_every,
    input  logic [CNT_W-1:0] cfg_lead,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic [NUM_W-1:0] cfg_count,
    output logic             accept,
    output logic             full_delay,
    output logic             pulse_out,
    output logic             busy
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [NUM_W-1:0] NUM_ONE = NUM_W'(1);

    phase_e           phase;
    logic [CNT_W-1:0] tick_cnt;
    logic [NUM_W-1:0] pulses_done;
    logic             first_pend;

    assign accept     = enable & trig & (phase == PH_IDLE);
    assign full_delay = delay_every | first_pend;
    assign pulse_out  = (phase == PH_HIGH);
    assign busy       = (phase != PH_IDLE);

    // Phase advance, tick counting and first-trigger tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            tick_cnt    <= '0;
            pulses_done <= '0;
            first_pend  <= 1'b1;
        end else if (!enable) begin
            phase       <= PH_IDLE;
            tick_cnt    <= '0;
            pulses_done <= '0;
            first_pend  <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (trig) begin
                        phase       <= PH_DELAY;
                        tick_cnt    <= '0;
                        pulses_done <= '0;
                        first_pend  <= 1'b0;
                    end
                end
                PH_DELAY: begin
                    if (tick) begin
                        if (tick_cnt == cfg_lead - CNT_ONE) begin
                            phase    <= PH_HIGH;
                            tick_cnt <= '0;
                        end else begin
                            tick_cnt <= tick_cnt + CNT_ONE;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (tick_cnt == cfg_width - CNT_ONE) begin
                            tick_cnt <= '0;
                            if (pulses_done == cfg_count - NUM_ONE) begin
                                phase <= PH_IDLE;
                            end else begin
                                phase       <= PH_LOW;
                                pulses_done <= pulses_done + NUM_ONE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + CNT_ONE;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (tick_cnt == cfg_gap - CNT_ONE) begin
                            phase    <= PH_HIGH;
                            tick_cnt <= '0;
                        end else begin
                            tick_cnt <= tick_cnt + CNT_ONE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/retrig_pulse_gen.sv
`timescale 1ns/1ps
// Module: retrig_pulse_gen (top)
// Retriggerable delayed pulse generator. Synchronizes gate and source,
// turns gate rising edges into triggers, counts selected source edges for
// delay / width / gap, and emits a pulse or pulse group per trigger.
// Assumes gate_in and src_in levels last at least two clk periods each.
module retrig_pulse_gen #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned NUM_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             gate_in,
    input  logic             src_in,
    input  logic             src_fall_sel,
    input  logic             delay_every,
    input  logic [CNT_W-1:0] delay_ticks,
    input  logic [CNT_W-1:0] width_ticks,
    input  logic [CNT_W-1:0] gap_ticks,
    input  logic [NUM_W-1:0] pulse_count,
    output logic             pulse_out,
    output logic             busy
);

    logic             gate_rise;
    logic             src_tick;
    logic             accept;
    logic             full_delay;
    logic [CNT_W-1:0] lead_q;
    logic [CNT_W-1:0] width_q;
    logic [CNT_W-1:0] gap_q;
    logic [NUM_W-1:0] count_q;

    rdpg_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (gate_in),
        .fall_sel   (1'b0),
        .edge_pulse (gate_rise)
    );

    rdpg_sync_edge #(.STAGES(SYNC_STAGES)) u_src_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (src_in),
        .fall_sel   (src_fall_sel),
        .edge_pulse (src_tick)
    );

    rdpg_cfg_latch #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .full_delay (full_delay),
        .delay_raw  (delay_ticks),
        .width_raw  (width_ticks),
        .gap_raw    (gap_ticks),
        .count_raw  (pulse_count),
        .lead_q     (lead_q),
        .width_q    (width_q),
        .gap_q      (gap_q),
        .count_q    (count_q)
    );

    rdpg_seq #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .trig        (gate_rise),
        .tick        (src_tick),
        .delay_every (delay_every),
        .cfg_lead    (lead_q),
        .cfg_width   (width_q),
        .cfg_gap     (gap_q),
        .cfg_count   (count_q),
        .accept      (accept),
        .full_delay  (full_delay),
        .pulse_out   (pulse_out),
        .busy        (busy)
    );

endmodule

// File: rtl/retrig_pulse_gen_chk.sv
`timescale 1ns/1ps
// Module: retrig_pulse_gen_chk
// Cycle-level protocol checks for retrig_pulse_gen, attached by bind.
module retrig_pulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tick,
    input logic pulse_out,
    input logic busy
);

    // R1: a reset cycle leaves both outputs low on the next edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pulse_out && !busy));

    // R7: the output is never high outside a generation.
    a_r7_pulse_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> busy);

    // R7: busy ends with the last pulse edge, or because of a disable.
    a_r7_busy_ends_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!pulse_out && ($past(pulse_out) || !$past(enable))));

    // R2: the minimum lead keeps the output low just after acceptance.
    a_r2_no_instant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !pulse_out);

    // R8: the output moves only on an active source tick or a disable.
    a_r8_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_out) |-> ($past(tick) || !$past(enable)));

    // R10: disabling idles the block on the next edge.
    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !pulse_out));

endmodule

bind retrig_pulse_gen retrig_pulse_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (src_tick),
    .pulse_out (pulse_out),
    .busy      (busy)
);

// File: tb/retrig_pulse_gen_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: fire() pushes the expected pulses into a queue, and a
// monitor measures each pulse in source edges driven by the bench.
module retrig_pulse_gen_bench;

    localparam int CNT_W = 16;
    localparam int NUM_W = 8;

    typedef struct packed {
        int lead;
        int width;
        bit first;
        bit last;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             gate_in = 1'b0;
    logic             src_in = 1'b0;
    logic             src_fall_sel = 1'b0;
    logic             delay_every = 1'b1;
    logic [CNT_W-1:0] delay_ticks = '0;
    logic [CNT_W-1:0] width_ticks = '0;
    logic [CNT_W-1:0] gap_ticks = '0;
    logic [NUM_W-1:0] pulse_count = '0;
    logic             pulse_out;
    logic             busy;

    int   total = 0;
    int   bad = 0;
    int   edge_cnt = 0;
    int   gate_snap = 0;
    bit   first_pend = 1'b1;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    event src_ev;

    always #4 clk = ~clk;

    retrig_pulse_gen #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_retrig_pulse_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .gate_in      (gate_in),
        .src_in       (src_in),
        .src_fall_sel (src_fall_sel),
        .delay_every  (delay_every),
        .delay_ticks  (delay_ticks),
        .width_ticks  (width_ticks),
        .gap_ticks    (gap_ticks),
        .pulse_count  (pulse_count),
        .pulse_out    (pulse_out),
        .busy         (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Source timebase: toggles every 5 clocks and counts the active edges.
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            src_in = ~src_in;
            if (src_in != src_fall_sel) edge_cnt++;
            -> src_ev;
        end
    end

    // Monitor: measures lead and width in source edges and compares them.
    initial begin
        bit   prev = 1'b0;
        int   rise_cnt = 0;
        int   last_fall = 0;
        exp_t cur;
        forever begin
            @(posedge clk);
            #2;
            if (pulse_out && !prev) begin
                rise_cnt = edge_cnt;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected pulse", 1, 0);
                end else begin
                    cur = exp_q[0];
                    check((rise_cnt - (cur.first ? gate_snap : last_fall)) == cur.lead,
                          "R2/R4/R5 lead edges",
                          rise_cnt - (cur.first ? gate_snap : last_fall), cur.lead);
                    check(busy == 1'b1, "R7 busy during pulse", busy, 1);
                end
            end
            if (!pulse_out && prev && exp_q.size() > 0) begin
                cur = exp_q.pop_front();
                last_fall = edge_cnt;
                check((edge_cnt - rise_cnt) == cur.width, "R3 width edges",
                      edge_cnt - rise_cnt, cur.width);
                check(busy == !cur.last, "R7 busy at pulse end", busy, !cur.last);
            end
            prev = pulse_out;
        end
    end

    // Drive a gate pulse placed mid-way between source toggles.
    task automatic gate_pulse(input bit snap);
        @(src_ev);
        repeat (2) @(negedge clk);
        gate_in = 1'b1;
        if (snap) gate_snap = edge_cnt;
        repeat (3) @(negedge clk);
        gate_in = 1'b0;
    endtask

    // Program, trigger and push the expected pulses (R2..R5 floors).
    task automatic fire(input int d, input int w, input int g, input int n);
        int lead;
        int wd;
        int gp;
        int cnt;
        bit full;
        full = delay_every || first_pend;
        lead = (full && d > 2) ? d : 2;
        wd   = (w < 1) ? 1 : w;
        gp   = (g < 1) ? 1 : g;
        cnt  = (n < 1) ? 1 : n;
        delay_ticks = CNT_W'(d);
        width_ticks = CNT_W'(w);
        gap_ticks   = CNT_W'(g);
        pulse_count = NUM_W'(n);
        for (int i = 0; i < cnt; i++) begin
            exp_t e;
            e.lead  = (i == 0) ? lead : gp;
            e.width = wd;
            e.first = (i == 0);
            e.last  = (i == cnt - 1);
            exp_q.push_back(e);
        end
        first_pend = 1'b0;
        gate_pulse(1'b1);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((exp_q.size() != 0 || busy) && n < 5000) begin
            @(posedge clk);
            n++;
        end
        check(n < 5000, req, n, 0);
        repeat (6) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #2;
        check(pulse_out == 1'b0, "R1 reset pulse_out", pulse_out, 0);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(busy == 1'b0, "R1 idle after reset", busy, 0);
        @(negedge clk);
        enable = 1'b1;
        first_pend = 1'b1;

        // R2/R3: single pulse, delay 5 width 3, then the same on retrigger.
        fire(5, 3, 1, 1);  wait_idle("R2 first single");
        fire(5, 3, 1, 1);  wait_idle("R2 retrigger full delay");
        // R5: delay only on first trigger -> minimum lead of 2.
        delay_every = 1'b0;
        fire(5, 3, 1, 1);  wait_idle("R5 minimum lead");
        delay_every = 1'b1;
        // R2 floor: delays 0 and 1 become 2; R3 floor: width 0 becomes 1.
        fire(0, 2, 1, 1);  wait_idle("R2 delay zero");
        fire(1, 0, 1, 1);  wait_idle("R3 width zero");
        // R4: groups, including count 0 and gap 0.
        fire(4, 2, 3, 4);  wait_idle("R4 group of four");
        fire(3, 2, 2, 0);  wait_idle("R4 count zero");
        fire(3, 1, 0, 3);  wait_idle("R4 gap zero");

        // R6: gate edges during delay and during a pulse are ignored.
        fire(6, 4, 2, 3);
        gate_pulse(1'b0);
        wait (pulse_out == 1'b1);
        gate_pulse(1'b0);
        wait_idle("R6 retrigger ignored");
        check(pulse_out == 1'b0, "R6 no pulse after end", pulse_out, 0);

        // R9: inputs changed mid-generation have no effect.
        fire(6, 3, 2, 2);
        repeat (20) @(negedge clk);
        delay_ticks = 16'd9; width_ticks = 16'd7; gap_ticks = 16'd5;
        pulse_count = 8'd4; delay_every = 1'b0;
        wait_idle("R9 config captured");
        delay_every = 1'b1;

        // R8: falling source edges.
        @(negedge clk);
        src_fall_sel = 1'b1;
        edge_cnt = 0;
        repeat (30) @(posedge clk);
        fire(3, 2, 1, 2);  wait_idle("R8 falling edges");
        @(negedge clk);
        src_fall_sel = 1'b0;
        edge_cnt = 0;
        repeat (30) @(posedge clk);

        // R10: disable during the delay abandons the generation.
        fire(20, 2, 1, 1);
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R10 busy before disable", busy, 1);
        enable = 1'b0;
        exp_q.delete();
        @(posedge clk); #2;
        check(busy == 1'b0, "R10 busy after disable", busy, 0);
        gate_pulse(1'b0);
        repeat (40) @(posedge clk); #2;
        check(busy == 1'b0 && pulse_out == 1'b0, "R10 gate ignored when disabled",
              busy, 0);
        // R5: re-arming makes the next trigger a first one again.
        @(negedge clk);
        enable = 1'b1;
        first_pend = 1'b1;
        delay_every = 1'b0;
        fire(7, 2, 1, 1);  wait_idle("R5 first after re-arm");
        fire(7, 2, 1, 1);  wait_idle("R5 later trigger minimum");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule